// File: doc/BRIEF.md
# NAND Flash Strobe Timing Engine

This block turns byte-level requests from a host into correctly timed strobe cycles on an 8-bit asynchronous NAND flash bus. Each request is one of four kinds: a command byte, an address byte, a data write or a data read. The block runs the request through three phases, setup, strobe pulse and hold. It can then wait for a programmed interval before the ready/busy line is considered valid. At the end it raises a one-cycle done pulse. Reads return the captured byte with that pulse.

A 32-bit timing word controls the phase lengths. It has one half for reads and one half for writes. Each half packs four 4-bit fields. A setup, pulse or hold field value n gives n+1 clocks. A ready-wait field value n gives 2*n clocks. The engine latches the relevant half when it accepts a request, so software may reprogram the word while an access is running. A configuration input can hold chip enable low across accesses. A synchronous soft-reset input aborts any access. A registered status output follows the ready/busy pin.

The request side is a valid/ready stream. `req_ready` is high only while the engine is idle and soft reset is low. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. The host may hold `req_valid` for as long as it needs to. The read result is not back-pressured: `rd_valid` is a one-cycle pulse, and the host must take `rd_data` on that pulse.

Top module: `nand_strobe_engine`

## Requirements
- R1: A request is accepted only when the engine is idle. `req_ready` stays low from the accepting edge until the done cycle.
- R2: For read requests, the timing word fields are: setup in bits 3:0, hold in bits 7:4, pulse width in bits 11:8 and ready-wait in bits 15:12. A setup, hold or width value n lasts n+1 clocks.
- R3: For command, address and data-write requests, the fields are: setup in bits 19:16, hold in bits 23:20, pulse width in bits 27:24 and ready-wait in bits 31:28. The read half has no effect on these requests.
- R4: After the hold phase, a ready-wait value n adds exactly 2*n idle-strobe clocks before done. A value of 0 adds none.
- R5: Kind 0 (command) drives `nand_cle` high from setup through hold. Kind 1 (address) drives `nand_ale` high over the same span. Kinds 2 (write data) and 3 (read data) drive neither line.
- R6: `nand_we_n` is low only during the pulse phase of kinds 0, 1 and 2. `nand_re_n` is low only during the pulse phase of kind 3.
- R7: For kinds 0 to 2, `nand_dq_oe` is high and `nand_dq_out` carries the request byte from the first setup clock to the last hold clock. The bus is never driven for reads or when idle.
- R8: A read captures `nand_dq_in` on the clock edge that ends the last pulse-width clock. The captured byte appears on `rd_data`, and `rd_valid` pulses together with done.
- R9: `nand_ce_n` is low from setup through hold of every access. While `ce_force` is high it is also low in idle and in the ready-wait phase.
- R10: `rdy_status` equals the value of `nand_rb` one clock earlier.
- R11: `done` is a single-cycle pulse in the first idle cycle after an access. In that cycle `req_ready` is already high.
- R12: `soft_reset` aborts any access. After the edge, the strobes and the bus are inactive, no done pulse follows for the aborted access, and `req_ready` is low while `soft_reset` is held.
- R13: Changing `tmg_word` during an access does not alter that access's phase lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_reset | input | 1 | Synchronous abort to idle |
| ce_force | input | 1 | Hold chip enable active across accesses |
| tmg_word | input | 32 | Read (15:0) and write (31:16) timing fields |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Engine idle and able to accept |
| req_kind | input | 2 | 0 command, 1 address, 2 write data, 3 read data |
| req_data | input | 8 | Byte for command, address or write |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_valid | output | 1 | Read byte valid (pulses with done) |
| rd_data | output | 8 | Captured read byte |
| rdy_status | output | 1 | Registered ready/busy pin |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_dq_out | output | 8 | Data bus drive value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus sampled value |
| nand_rb | input | 1 | Ready/busy pin, 1 = ready |

## Verification
The bench builds the engine with its default 8-bit data path, which matches the fixed 4-bit field layout. It drives timing words whose fields run from zero up to the maximum of 15. This reaches the shortest three-clock read, the longest pulse phase and ready-waits of several lengths. It compares every pin in every cycle of each access against a phase trace computed from the word. The read-data pattern changes on every pulse clock, which pins down the exact capture edge. Mid-access timing changes, forced chip enable and an aborted access cover the latching, the chip-enable and the soft-reset rules.

// File: rtl/nse_pkg.sv
package nse_pkg;
  localparam int FIELD_W = 4;
  localparam int HALF_W  = 4 * FIELD_W;
  localparam int TMG_W   = 2 * HALF_W;
  localparam int CNT_W   = FIELD_W + 1;

  typedef enum logic [1:0] {
    K_CMD   = 2'd0,
    K_ADDR  = 2'd1,
    K_WDATA = 2'd2,
    K_RDATA = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD,
    PH_WAIT
  } phase_e;

  // Packed so that a timing half maps directly: wait|width|hold|setup
  typedef struct packed {
    logic [FIELD_W-1:0] wait_n;
    logic [FIELD_W-1:0] width;
    logic [FIELD_W-1:0] hold;
    logic [FIELD_W-1:0] setup;
  } tmg_t;
endpackage

// File: rtl/nse_tmg_sel.sv
module nse_tmg_sel
  import nse_pkg::*;
(
  input  logic [TMG_W-1:0] tmg_word,
  input  logic             is_read,
  output tmg_t             sel
);
  logic [HALF_W-1:0] half;

  always_comb begin
    half = is_read ? tmg_word[HALF_W-1:0] : tmg_word[TMG_W-1:HALF_W];
    sel  = tmg_t'(half);
  end
endmodule

// File: rtl/nse_phase_seq.sv
module nse_phase_seq
  import nse_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   soft_reset,
  input  logic   start,
  input  tmg_t   tmg_in,
  output phase_e phase,
  output logic   phase_last,
  output logic   done
);
  logic [CNT_W-1:0]   cnt;
  logic [FIELD_W-1:0] width_q, hold_q, wait_q;

  assign phase_last = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      width_q <= '0;
      hold_q  <= '0;
      wait_q  <= '0;
      done    <= 1'b0;
    end else if (soft_reset) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start) begin
          width_q <= tmg_in.width;
          hold_q  <= tmg_in.hold;
          wait_q  <= tmg_in.wait_n;
          cnt     <= {1'b0, tmg_in.setup};
          phase   <= PH_SETUP;
        end
        PH_SETUP: if (phase_last) begin
          cnt   <= {1'b0, width_q};
          phase <= PH_PULSE;
        end else cnt <= cnt - CNT_W'(1);
        PH_PULSE: if (phase_last) begin
          cnt   <= {1'b0, hold_q};
          phase <= PH_HOLD;
        end else cnt <= cnt - CNT_W'(1);
        PH_HOLD: if (phase_last) begin
          if (wait_q == '0) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            cnt   <= {wait_q, 1'b0} - CNT_W'(1);
            phase <= PH_WAIT;
          end
        end else cnt <= cnt - CNT_W'(1);
        PH_WAIT: if (phase_last) begin
          phase <= PH_IDLE;
          done  <= 1'b1;
        end else cnt <= cnt - CNT_W'(1);
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nse_pin_drive.sv
module nse_pin_drive
  import nse_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_reset,
  input  logic              start,
  input  req_kind_e         kind_in,
  input  logic [DATA_W-1:0] data_in,
  input  phase_e            phase,
  input  logic              phase_last,
  input  logic              done,
  input  logic              ce_force,
  input  logic [DATA_W-1:0] dq_in,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic              ce_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  req_kind_e         kind_q;
  logic [DATA_W-1:0] data_q;
  logic              active, pulse, is_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= K_CMD;
      data_q  <= '0;
      rd_data <= '0;
    end else if (!soft_reset) begin
      if (start) begin
        kind_q <= kind_in;
        data_q <= data_in;
      end
      if (pulse && phase_last && is_rd) rd_data <= dq_in;
    end
  end

  always_comb begin
    active   = (phase == PH_SETUP) || (phase == PH_PULSE) || (phase == PH_HOLD);
    pulse    = (phase == PH_PULSE);
    is_rd    = (kind_q == K_RDATA);
    cle      = active && (kind_q == K_CMD);
    ale      = active && (kind_q == K_ADDR);
    we_n     = !(pulse && !is_rd);
    re_n     = !(pulse && is_rd);
    ce_n     = !(active || ce_force);
    dq_oe    = active && !is_rd;
    dq_out   = dq_oe ? data_q : '0;
    rd_valid = done && is_rd;
  end
endmodule

// File: rtl/nand_strobe_engine.sv
module nand_strobe_engine
  import nse_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_reset,
  input  logic              ce_force,
  input  logic [TMG_W-1:0]  tmg_word,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [DATA_W-1:0] req_data,
  output logic              done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rdy_status,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic              nand_ce_n,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_in,
  input  logic              nand_rb
);
  phase_e    phase;
  logic      phase_last;
  logic      start;
  req_kind_e kind;
  tmg_t      tmg_sel;

  assign kind      = req_kind_e'(req_kind);
  assign req_ready = (phase == PH_IDLE) && !soft_reset;
  assign start     = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_status <= 1'b0;
    else        rdy_status <= nand_rb;
  end

  nse_tmg_sel u_sel (
    .tmg_word (tmg_word),
    .is_read  (kind == K_RDATA),
    .sel      (tmg_sel)
  );

  nse_phase_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_reset (soft_reset),
    .start      (start),
    .tmg_in     (tmg_sel),
    .phase      (phase),
    .phase_last (phase_last),
    .done       (done)
  );

  nse_pin_drive #(.DATA_W(DATA_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_reset (soft_reset),
    .start      (start),
    .kind_in    (kind),
    .data_in    (req_data),
    .phase      (phase),
    .phase_last (phase_last),
    .done       (done),
    .ce_force   (ce_force),
    .dq_in      (nand_dq_in),
    .cle        (nand_cle),
    .ale        (nand_ale),
    .we_n       (nand_we_n),
    .re_n       (nand_re_n),
    .ce_n       (nand_ce_n),
    .dq_out     (nand_dq_out),
    .dq_oe      (nand_dq_oe),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );
endmodule

// File: rtl/nse_checker.sv
module nse_checker (
  input logic clk,
  input logic rst_n,
  input logic soft_reset,
  input logic req_valid,
  input logic req_ready,
  input logic nand_rb,
  input logic rdy_status,
  input logic done,
  input logic rd_valid,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_dq_oe
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_cle_ale_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  p_rd_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> done);

  p_status_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |=> (rdy_status == $past(nand_rb)));

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_abort_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    soft_reset |=> (nand_we_n && nand_re_n && !nand_dq_oe && !done));
endmodule

bind nand_strobe_engine nse_checker u_chk (.*);

// File: tb/nand_strobe_engine_tb.sv
module nand_strobe_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_reset = 1'b0;
  logic        ce_force = 1'b0;
  logic [31:0] tmg_word = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [7:0]  req_data = '0;
  logic        done, rd_valid, rdy_status;
  logic [7:0]  rd_data;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_ce_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in = '0;
  logic        nand_rb = 1'b1;

  int nvec = 0;
  int nfail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_strobe_engine u_dut (
    .clk(clk), .rst_n(rst_n), .soft_reset(soft_reset), .ce_force(ce_force),
    .tmg_word(tmg_word), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_data(req_data), .done(done), .rd_valid(rd_valid),
    .rd_data(rd_data), .rdy_status(rdy_status), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_ce_n(nand_ce_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // packs {cle,ale,we_n,re_n,ce_n,oe,ready,done}
  function automatic logic [7:0] pins();
    return {nand_cle, nand_ale, nand_we_n, nand_re_n, nand_ce_n, nand_dq_oe, req_ready, done};
  endfunction

  // One access, checked cycle by cycle against a trace derived from the word.
  task automatic run_access(input logic [1:0] kind, input logic [7:0] data,
                            input logic [31:0] tw, input logic [7:0] dqbase,
                            input bit change_tmg);
    logic [15:0] half;
    int s, h, w, n, act_len, total;
    logic [7:0] exp;
    half = (kind == 2'd3) ? tw[15:0] : tw[31:16];
    s = int'(half[3:0]); h = int'(half[7:4]); w = int'(half[11:8]); n = int'(half[15:12]);
    act_len = s + w + h + 3;
    total   = act_len + 2 * n;
    @(negedge clk);
    tmg_word = tw; req_kind = kind; req_data = data; req_valid = 1'b1;
    #1 chk(req_ready == 1'b1, "R1 idle ready", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    if (change_tmg) tmg_word = ~tw;
    for (int k = 0; k < total; k++) begin
      bit a, p;
      a = (k < act_len);
      p = (k >= s + 1) && (k < s + w + 2);
      nand_dq_in = p ? (dqbase ^ 8'(k)) : ~dqbase;
      exp = {a && kind == 2'd0, a && kind == 2'd1, !(p && kind != 2'd3),
             !(p && kind == 2'd3), !(a || ce_force), a && kind != 2'd3, 1'b0, 1'b0};
      #1;
      chk(pins() == exp, "R1/R2/R3/R4/R5/R6/R7/R9/R13 phase trace", {24'd0, pins()}, {24'd0, exp});
      if (a && kind != 2'd3)
        chk(nand_dq_out == data, "R7 bus byte", {24'd0, nand_dq_out}, {24'd0, data});
      @(negedge clk);
    end
    #1;
    exp = {1'b0, 1'b0, 1'b1, 1'b1, !ce_force, 1'b0, 1'b1, 1'b1};
    chk(pins() == exp, "R11 done cycle", {24'd0, pins()}, {24'd0, exp});
    chk(rd_valid == (kind == 2'd3), "R8 rd_valid with done", {31'd0, rd_valid}, {31'd0, kind == 2'd3});
    if (kind == 2'd3)
      chk(rd_data == (dqbase ^ 8'(s + w + 1)), "R8 capture edge",
          {24'd0, rd_data}, {24'd0, dqbase ^ 8'(s + w + 1)});
    @(negedge clk); #1;
    chk(done == 1'b0 && rd_valid == 1'b0, "R11 single pulse", {30'd0, done, rd_valid}, 32'd0);
  endtask

  task automatic t_reset();
    #1;
    chk(pins() == {1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}, "R9/R11 reset pins",
        {24'd0, pins()}, {24'd0, 8'b00111010});
    chk(rd_data == 8'd0, "R8 reset rd_data", {24'd0, rd_data}, 32'd0);
  endtask

  task automatic t_status();
    @(negedge clk); nand_rb = 1'b0;
    @(negedge clk); #1 chk(rdy_status == 1'b0, "R10 busy seen", {31'd0, rdy_status}, 32'd0);
    nand_rb = 1'b1;
    @(negedge clk); #1 chk(rdy_status == 1'b1, "R10 ready seen", {31'd0, rdy_status}, 32'd1);
  endtask

  task automatic t_ce_force();
    @(negedge clk); ce_force = 1'b1;
    #1 chk(nand_ce_n == 1'b0, "R9 forced in idle", {31'd0, nand_ce_n}, 32'd0);
    run_access(2'd2, 8'h3C, 32'h2111_0000, 8'h00, 1'b0);
    #1 chk(nand_ce_n == 1'b0, "R9 still forced", {31'd0, nand_ce_n}, 32'd0);
    ce_force = 1'b0;
    #1 chk(nand_ce_n == 1'b1, "R9 released", {31'd0, nand_ce_n}, 32'd1);
  endtask

  task automatic t_soft_reset();
    @(negedge clk);
    tmg_word = 32'hFFFF_FFFF; req_kind = 2'd2; req_data = 8'h77; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    repeat (3) @(negedge clk);
    soft_reset = 1'b1;
    #1 chk(req_ready == 1'b0, "R12 not ready in reset", {31'd0, req_ready}, 32'd0);
    @(negedge clk); #1;
    chk(nand_we_n && nand_re_n && !nand_dq_oe && nand_ce_n && !nand_cle,
        "R12 pins idle", {24'd0, pins()}, 32'h3A);
    soft_reset = 1'b0;
    #1 chk(req_ready == 1'b1, "R12 ready after release", {31'd0, req_ready}, 32'd1);
    begin
      int seen;
      seen = 0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk); #1;
        if (done) seen++;
      end
      chk(seen == 0, "R12 no done after abort", seen, 32'd0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    // R3: command with write fields; the read half is all ones and must not matter
    run_access(2'd0, 8'h70, 32'h0231_FFFF, 8'h00, 1'b0);
    // R3/R4: address with one ready-wait step
    run_access(2'd1, 8'h12, 32'h1102_0000, 8'h00, 1'b0);
    // R3/R4: data write, max width, wait of three steps
    run_access(2'd2, 8'hA5, 32'h3F0A_5555, 8'h00, 1'b0);
    // R2/R8: data read with non-zero fields
    run_access(2'd3, 8'h00, 32'hFFFF_2513, 8'h5A, 1'b0);
    // R2: shortest read, all fields zero
    run_access(2'd3, 8'h00, 32'h0000_0000, 8'hC3, 1'b0);
    // R13: timing word changes right after acceptance
    run_access(2'd2, 8'h0F, 32'h2324_0000, 8'h00, 1'b1);
    run_access(2'd3, 8'h00, 32'h0000_1F42, 8'h81, 1'b1);
    t_ce_force();
    t_status();
    t_soft_reset();
    // R1: engine usable again after an abort
    run_access(2'd0, 8'hFF, 32'h0000_0000, 8'h00, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end
endmodule